// File: doc/BRIEF.md
# Clock Not-Recently-Used Victim Selector

This block picks a replacement frame among a fixed pool of physical frames using the clock (second-chance) policy. Each frame carries one use bit that is set whenever the frame is referenced. A single hand points at one frame. On a fault request the block walks forward from the hand, one frame per clock. A frame whose use bit is set gets the bit cleared and is skipped. The first frame found with a clear bit is reported as the victim. The result is an old page, not necessarily the oldest one.

The hand stays still between faults. After a victim is chosen the hand steps past it, so the next scan starts at the following frame. References keep arriving during a scan. When a reference and the scan's clear hit the same frame in the same cycle, the reference wins.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all use bits are clear, the hand is at frame 0, `victim_valid_o` and `busy_o` are low and `victim_idx_o` is 0.
- R2: A cycle with `ref_valid_i` high sets the use bit of frame `ref_idx_i`, so that frame is skipped once by a later scan.
- R3: A scan examines frames starting at the hand and reports as victim the first examined frame whose use bit was clear when it was examined.
- R4: Each examined frame whose use bit is set has that bit cleared, so a later scan reaching it without a new reference selects it.
- R5: One frame is examined per clock. The request is seen at edge k, and the first frame is examined at edge k+1. With j skipped frames, `victim_valid_o` goes high after edge k+1+j.
- R6: `victim_valid_o` is high for exactly one cycle per scan, with `victim_idx_o` valid in that cycle and held afterwards.
- R7: The hand moves only during a scan. It ends one frame past the victim and wraps from frame NUM_FRAMES-1 to frame 0.
- R8: A reference to the frame being examined in the same cycle leaves its use bit set.
- R9: With no references during a scan, the victim is found within NUM_FRAMES+1 examined frames.
- R10: `fault_req_i` is ignored while a scan is in progress and produces no extra victim.
- R11: `busy_o` is high from the cycle after an accepted request through the cycle that examines the victim frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_valid_i | input | 1 | Frame reference strobe |
| ref_idx_i | input | IDX_W | Referenced frame index |
| fault_req_i | input | 1 | Fault request, accepted when not busy |
| busy_o | output | 1 | Scan in progress |
| victim_valid_o | output | 1 | One-cycle victim strobe |
| victim_idx_o | output | IDX_W | Selected victim frame |

## Verification
The first pattern is a fault on an idle pool, which gives the immediate-victim latency and the reset hand position. Next come faults after a few references, which show the skip and the clear apart from the plain hand advance. A fault after every frame has been referenced drives the full-wrap worst case. Two further cases are a reference timed onto the frame under examination, and requests repeated while busy. These separate reference priority and the ignoring of repeated requests from ordinary scanning. A long random mix of references and faults is then compared cycle by cycle against a behavioural model of the policy.

// File: rtl/clk_nru_pkg.sv
package clk_nru_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;
endpackage

// File: rtl/clk_nru_use_bits.sv
module clk_nru_use_bits #(
  parameter int unsigned NUM_FRAMES = 16,
  parameter int unsigned IDX_W      = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_en_i,
  input  logic [IDX_W-1:0]      set_idx_i,
  input  logic                  clr_en_i,
  input  logic [IDX_W-1:0]      clr_idx_i,
  output logic [NUM_FRAMES-1:0] use_o
);
  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_bit
    logic set_hit, clr_hit;
    assign set_hit = set_en_i && (set_idx_i == IDX_W'(g));
    assign clr_hit = clr_en_i && (clr_idx_i == IDX_W'(g));
    // reference wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      use_o[g] <= 1'b0;
      else if (set_hit) use_o[g] <= 1'b1;
      else if (clr_hit) use_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_nru_hand.sv
module clk_nru_hand #(
  parameter int unsigned NUM_FRAMES = 16,
  parameter int unsigned IDX_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] hand_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hand_o <= '0;
    else if (adv_i) hand_o <= (hand_o == LAST) ? '0 : hand_o + 1'b1;
  end
endmodule

// File: rtl/clk_nru_scan_ctrl.sv
module clk_nru_scan_ctrl
  import clk_nru_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_req_i,
  input  logic             use_at_hand_i,
  input  logic [IDX_W-1:0] hand_i,
  output logic             clr_en_o,
  output logic             adv_o,
  output logic             busy_o,
  output logic             victim_valid_o,
  output logic [IDX_W-1:0] victim_idx_o
);
  scan_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      victim_valid_o <= 1'b0;
      victim_idx_o   <= '0;
    end else begin
      victim_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (fault_req_i) state_q <= ST_SCAN;
        ST_SCAN: if (!use_at_hand_i) begin
          victim_valid_o <= 1'b1;
          victim_idx_o   <= hand_i;
          state_q        <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o   = (state_q == ST_SCAN);
    adv_o    = busy_o;                 // step on every examine, also past victim
    clr_en_o = busy_o && use_at_hand_i;
  end
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int unsigned NUM_FRAMES = 16,
  localparam int unsigned IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_valid_i,
  input  logic [IDX_W-1:0] ref_idx_i,
  input  logic             fault_req_i,
  output logic             busy_o,
  output logic             victim_valid_o,
  output logic [IDX_W-1:0] victim_idx_o
);
  logic [NUM_FRAMES-1:0] use_q;
  logic [IDX_W-1:0]      hand_q;
  logic                  use_at_hand, clr_en, adv;

  assign use_at_hand = use_q[hand_q];

  clk_nru_use_bits #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_use (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (ref_valid_i),
    .set_idx_i (ref_idx_i),
    .clr_en_i  (clr_en),
    .clr_idx_i (hand_q),
    .use_o     (use_q)
  );

  clk_nru_hand #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_hand (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .hand_o (hand_q)
  );

  clk_nru_scan_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fault_req_i    (fault_req_i),
    .use_at_hand_i  (use_at_hand),
    .hand_i         (hand_q),
    .clr_en_o       (clr_en),
    .adv_o          (adv),
    .busy_o         (busy_o),
    .victim_valid_o (victim_valid_o),
    .victim_idx_o   (victim_idx_o)
  );
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int unsigned NUM_FRAMES = 16,
  parameter int unsigned IDX_W      = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  ref_valid_i,
  input logic [IDX_W-1:0]      ref_idx_i,
  input logic                  busy_o,
  input logic                  victim_valid_o,
  input logic [IDX_W-1:0]      victim_idx_o,
  input logic [NUM_FRAMES-1:0] use_q,
  input logic [IDX_W-1:0]      hand_q
);
  logic [IDX_W+1:0] scan_len;
  logic             ref_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_len <= '0;
      ref_seen <= 1'b0;
    end else if (!busy_o) begin
      scan_len <= '0;
      ref_seen <= 1'b0;
    end else begin
      if (scan_len != '1) scan_len <= scan_len + 1'b1;
      if (ref_valid_i) ref_seen <= 1'b1;
    end
  end

  AST_VICTIM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |=> !victim_valid_o); // R6

  AST_REF_SETS_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && (int'(ref_idx_i) < NUM_FRAMES)) |=> use_q[$past(ref_idx_i)]); // R2

  AST_VICTIM_WAS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> (($past(use_q) >> victim_idx_o) & 1) == 0); // R3

  AST_HAND_PAST_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> int'(hand_q) == (int'(victim_idx_o) + 1) % NUM_FRAMES); // R7

  AST_HAND_STILL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(hand_q)); // R7

  AST_SCAN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ref_seen) |-> int'(scan_len) <= NUM_FRAMES); // R9
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ref_valid_i    (ref_valid_i),
  .ref_idx_i      (ref_idx_i),
  .busy_o         (busy_o),
  .victim_valid_o (victim_valid_o),
  .victim_idx_o   (victim_idx_o),
  .use_q          (use_q),
  .hand_q         (hand_q)
);

// File: tb/clock_victim_sel_tb_top.sv
module clock_victim_sel_tb_top;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ref_valid = 1'b0;
  logic [W-1:0] ref_idx = '0;
  logic         fault_req = 1'b0;
  logic         busy, vv;
  logic [W-1:0] vidx;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural reference
  bit use_m[N];
  int hand_m = 0;
  bit busy_m = 0;
  bit vv_m   = 0;
  int idx_m  = 0;

  bit obs_vv;
  int obs_idx;

  always #4 clk = ~clk;

  clock_victim_sel #(.NUM_FRAMES(N)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .ref_valid_i    (ref_valid),
    .ref_idx_i      (ref_idx),
    .fault_req_i    (fault_req),
    .busy_o         (busy),
    .victim_valid_o (vv),
    .victim_idx_o   (vidx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit rv, input int ri, input bit fr);
    bit u;
    vv_m = 0;
    if (busy_m) begin
      u = use_m[hand_m];
      if (u) use_m[hand_m] = 0;
      else begin
        vv_m = 1; idx_m = hand_m; busy_m = 0;
      end
      hand_m = (hand_m + 1) % N;
    end else if (fr) busy_m = 1;
    if (rv) use_m[ri] = 1;
  endtask

  task automatic cyc(input bit rv, input int ri, input bit fr);
    @(negedge clk);
    chk(busy == busy_m, "R11 busy", int'(busy), int'(busy_m));
    chk(vv == vv_m, "R6 victim_valid", int'(vv), int'(vv_m));
    chk(int'(vidx) == idx_m, "R3 victim_idx", int'(vidx), idx_m);
    obs_vv  = vv;
    obs_idx = int'(vidx);
    ref_valid = rv;
    ref_idx   = W'(ri);
    fault_req = fr;
    model_step(rv, ri, fr);
  endtask

  task automatic do_fault(input int exp_idx, input int exp_lat, input string tag,
                          input bit rv0, input int ri0);
    int lat;
    cyc(0, 0, 1);
    cyc(rv0, ri0, 0);
    lat = 1;
    while (!obs_vv && lat < 40) begin
      cyc(0, 0, 0);
      lat++;
    end
    chk(obs_vv && obs_idx == exp_idx, {tag, " victim"}, obs_idx, exp_idx);
    chk(lat == exp_lat, {tag, " R5 latency"}, lat, exp_lat);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R9 watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    int pulses;
    for (int i = 0; i < N; i++) use_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!vv && !busy && vidx == '0, "R1 reset outputs", {30'd0, vv, busy}, 0);

    do_fault(0, 2, "R3 idle pool", 0, 0);            // hand -> 1
    cyc(1, 1, 0); cyc(1, 2, 0);
    do_fault(3, 4, "R2 R4 skip referenced", 0, 0);   // hand -> 4
    do_fault(4, 2, "R7 hand past victim", 0, 0);     // hand -> 5
    for (int i = 0; i < N; i++) cyc(1, i, 0);
    do_fault(5, N + 2, "R9 full wrap", 0, 0);        // hand -> 6, all clear
    cyc(1, 6, 0); cyc(1, 7, 0);
    do_fault(0, 4, "R8 ref during examine", 1, 6);   // 6 kept, 7 cleared
    for (int i = 1; i <= 5; i++) do_fault(i, 2, "R7 sequential", 0, 0);
    do_fault(7, 3, "R8 kept bit skipped", 0, 0);     // hand -> 0

    // R10: repeated requests while busy
    cyc(1, 0, 0); cyc(1, 1, 0);
    pulses = 0;
    cyc(0, 0, 1);
    for (int i = 0; i < 11; i++) begin
      cyc(0, 0, (i < 3));
      if (obs_vv) begin
        pulses++;
        chk(obs_idx == 2, "R10 victim", obs_idx, 2);
      end
    end
    chk(pulses == 1, "R10 victim count", pulses, 1);
    chk(!busy, "R10 idle after", int'(busy), 0);

    // random mix, compared every cycle
    for (int i = 0; i < 4000; i++)
      cyc($urandom_range(0, 3) == 0, $urandom_range(0, N - 1), $urandom_range(0, 5) == 0);
    cyc(0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule